// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block merges four reset requests into one internal reset that is aligned to the system clock. The requests are an external active-low reset pin, a low-supply comparator flag, a USB bus-reset indication and a one-cycle watchdog timeout pulse. The block drives an active-high reset to the CPU and an active-low copy of the same reset to a peripheral module.

The pin, the low-supply flag and the USB indication arrive asynchronously. Each one passes through a two-flop synchronizer. The pin must then stay low for a long run of consecutive clock samples before it counts as a request. The low-supply flag needs a shorter run, which rejects brief supply dips. Once every request has gone away, the reset is held for a fixed number of clock cycles before it is released. Because the count is in cycles, the hold time scales with the clock frequency.

Two small registers sit alongside the reset logic. The first is a low-voltage enable bit. It is set at power-on and by every reset except one caused only by the watchdog, and software can clear or set it. The second is a sticky cause register that records which sources caused the most recent reset. Software clears it by writing ones to the bits it wants cleared. Nothing in the low-voltage path depends on CPU idle or power-down state, so that path keeps working in every low-power mode.

Top module: `reset_supervisor`

## Requirements
- R1: The external pin is accepted only after its synchronized value has been low for EXT_FILT consecutive clock samples. A shorter low pulse causes no reset and leaves `rst_cause` at zero.
- R2: A USB bus-reset pulse of one cycle or more, after its two-flop synchronizer, forces `cpu_rst` high. A one-cycle `wdt_expire` pulse forces `cpu_rst` high at the next clock edge.
- R3: After the last clock edge that sees a request, `cpu_rst` stays high for exactly STRETCH_CYC further edges. A single `wdt_expire` pulse therefore keeps `cpu_rst` high for STRETCH_CYC+1 cycles.
- R4: `periph_rst_n` is the inverse of `cpu_rst` in every cycle.
- R5: The low-supply flag is accepted only after LV_FILT consecutive high synchronized samples. Shorter dips cause no reset.
- R6: `lvr_en` is 1 after power-on, and any reset with a non-watchdog source sets it to 1. A register write with `reg_sel`=0 loads `reg_wdata[0]` into `lvr_en`, but only while `cpu_rst` is low. While `lvr_en` is 0, the low-supply flag causes no reset.
- R7: A reset whose only source is the watchdog leaves `lvr_en` unchanged.
- R8: The bits of `rst_cause` are: bit 0 external pin, bit 1 low supply, bit 2 USB, bit 3 watchdog. The first cycle of a new reset replaces the register with the sources active at that moment. Sources that appear while the reset is still active are ORed in. Power-on clears the register.
- R9: A register write with `reg_sel`=1 clears each `rst_cause` bit whose `reg_wdata` bit is 1 and keeps the others. Such writes are ignored while `cpu_rst` is high.
- R10: While `pwr_on_n` is low, `cpu_rst` is high. After `pwr_on_n` is released, `cpu_rst` stays high for STRETCH_CYC more edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_on_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lowv_det | input | 1 | Supply-below-threshold flag, asynchronous |
| usb_bus_rst | input | 1 | USB bus-reset indication, asynchronous |
| wdt_expire | input | 1 | Watchdog timeout pulse, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the cause register |
| reg_wdata | input | 4 | Register write data |
| cpu_rst | output | 1 | CPU reset, active high |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| lvr_en | output | 1 | Low-voltage reset enable |
| rst_cause | output | 4 | Sticky reset-cause flags |

## Verification
The assertions check the following rules on every cycle:
- any active request raises the reset at the next edge;
- the stretch counter only counts down while no request is present, and the reset never falls while a request or a nonzero count remains;
- each filter output rises only after the input has been asserted;
- the enable bit is set by non-watchdog sources and stays put during a watchdog-only reset;
- every active source lands in the cause register;
- the cause register never gains a bit outside a reset.

Some behaviour depends on run lengths and on sequences, so only the bench scenarios can show it. This covers the exact filter thresholds at the accept and reject boundaries, the exact stretch length after power-on and after a watchdog pulse, replacement of the cause register when a new reset starts, and writes being dropped during reset.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_EXT  = 0;
  localparam int SRC_LOWV = 1;
  localparam int SRC_USB  = 2;
  localparam int SRC_WDT  = 3;

  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_CAUSE = 1'b1;

  localparam logic [NSRC-1:0] WDT_MASK = NSRC'(1) << SRC_WDT;

  // width of a counter that must reach the value n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // write-one-to-clear update
  function automatic logic [NSRC-1:0] w1c(input logic [NSRC-1:0] cur,
                                          input logic [NSRC-1:0] wd);
    return cur & ~wd;
  endfunction

  // true when at least one source other than the watchdog is present
  function automatic logic has_hard_src(input logic [NSRC-1:0] s);
    return |(s & ~WDT_MASK);
  endfunction
endpackage

// File: rtl/rsv_sync2.sv
module rsv_sync2 #(
  parameter int         W    = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rsv_filter.sv
module rsv_filter #(
  parameter int RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_act,
  output logic act
);
  import rsv_pkg::*;
  localparam int CW = cnt_width(RUN);
  localparam logic [CW-1:0] FULL = CW'(RUN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (!in_act)     run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + CW'(1);
  end

  assign act = (run_q == FULL);

  AST_FILT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(in_act));                                   // R1 R5
  AST_FILT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_act |=> !act);                                               // R5
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rst_out,
  output logic busy
);
  import rsv_pkg::*;
  localparam int CW = cnt_width(STRETCH);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [CW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
      rst_q <= 1'b1;
    end else begin
      if (req)              cnt_q <= LOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      rst_q <= req | (cnt_q != '0);
    end
  end

  assign busy    = (cnt_q != '0);
  assign rst_out = rst_q;

  AST_REQ_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rst_out);                                                // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req) |=> (cnt_q == $past(cnt_q) - CW'(1)));            // R3
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (!$past(req) && !$past(busy)));               // R3
endmodule

// File: rtl/rsv_regs.sv
module rsv_regs (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_reset,
  input  logic [rsv_pkg::NSRC-1:0]  src,
  input  logic                      wr,
  input  logic                      sel,
  input  logic [rsv_pkg::NSRC-1:0]  wdata,
  output logic                      lvr_en,
  output logic [rsv_pkg::NSRC-1:0]  cause
);
  import rsv_pkg::*;

  logic hard_src;
  logic episode_start;
  logic sw_ctrl_wr;
  logic sw_cause_wr;

  assign hard_src      = has_hard_src(src);
  assign episode_start = (|src) && !in_reset;
  assign sw_ctrl_wr    = wr && !in_reset && (sel == SEL_CTRL);
  assign sw_cause_wr   = wr && !in_reset && (sel == SEL_CAUSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lvr_en <= 1'b1;
    else if (hard_src)   lvr_en <= 1'b1;
    else if (sw_ctrl_wr) lvr_en <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cause <= '0;
    else if (episode_start) cause <= src;
    else if (in_reset)      cause <= cause | src;
    else if (sw_cause_wr)   cause <= w1c(cause, wdata);
  end

  AST_LVR_SET_BY_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    hard_src |=> lvr_en);                                            // R6
  AST_WDT_KEEPS_LVREN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && !hard_src) |=> $stable(lvr_en));                    // R7
  AST_CAUSE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> ((cause & $past(src)) == $past(src)));                // R8
  AST_CAUSE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_reset && !(|src)) |=> ((cause & ~$past(cause)) == '0));     // R9
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int STRETCH_CYC = 400000,
  parameter int EXT_FILT    = 40000,
  parameter int LV_FILT     = 40
) (
  input  logic       clk,
  input  logic       pwr_on_n,
  input  logic       ext_rst_n,
  input  logic       lowv_det,
  input  logic       usb_bus_rst,
  input  logic       wdt_expire,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [3:0] reg_wdata,
  output logic       cpu_rst,
  output logic       periph_rst_n,
  output logic       lvr_en,
  output logic [3:0] rst_cause
);
  import rsv_pkg::*;

  localparam int NFILT = 2;
  localparam int FILT_RUN [NFILT] = '{EXT_FILT, LV_FILT};

  // synchronized async inputs: bit0 pin level, bit1 low supply, bit2 usb
  logic [2:0]       async_s;
  logic [NFILT-1:0] filt_in;
  logic [NFILT-1:0] filt_out;
  logic             usb_s;
  logic [NSRC-1:0]  src_vec;
  logic             any_req;
  logic             stretch_busy;
  logic             rst_int;

  rsv_sync2 #(.W(3), .IDLE(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (pwr_on_n),
    .d     ({usb_bus_rst, lowv_det, ext_rst_n}),
    .q     (async_s)
  );

  assign filt_in = {async_s[1], ~async_s[0]};
  assign usb_s   = async_s[2];

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    rsv_filter #(.RUN(FILT_RUN[g])) u_filt (
      .clk    (clk),
      .rst_n  (pwr_on_n),
      .in_act (filt_in[g]),
      .act    (filt_out[g])
    );
  end

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_EXT]  = filt_out[0];
    src_vec[SRC_LOWV] = filt_out[1] & lvr_en;
    src_vec[SRC_USB]  = usb_s;
    src_vec[SRC_WDT]  = wdt_expire;
  end

  assign any_req = |src_vec;

  rsv_stretch #(.STRETCH(STRETCH_CYC)) u_stretch (
    .clk     (clk),
    .rst_n   (pwr_on_n),
    .req     (any_req),
    .rst_out (rst_int),
    .busy    (stretch_busy)
  );

  rsv_regs u_regs (
    .clk      (clk),
    .rst_n    (pwr_on_n),
    .in_reset (rst_int),
    .src      (src_vec),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .lvr_en   (lvr_en),
    .cause    (rst_cause)
  );

  assign cpu_rst      = rst_int;
  assign periph_rst_n = ~rst_int;

  AST_LV_MASKED: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (!lvr_en && !cpu_rst && !stretch_busy && !filt_out[0] && !usb_s && !wdt_expire)
      |=> !cpu_rst);                                                 // R6
  AST_WDT_HITS: assert property (@(posedge clk) disable iff (!pwr_on_n)
    wdt_expire |=> (cpu_rst && rst_cause[SRC_WDT]));                 // R2
endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;
  localparam int S     = 20;
  localparam int EXT_N = 8;
  localparam int LV_N  = 4;

  logic       clk = 1'b0;
  logic       pwr_on_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       lowv_det = 1'b0;
  logic       usb_bus_rst = 1'b0;
  logic       wdt_expire = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic       cpu_rst;
  logic       periph_rst_n;
  logic       lvr_en;
  logic [3:0] rst_cause;

  int total = 0;
  int bad = 0;
  int hi_cnt = 0;
  int pmis = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reset_supervisor #(.STRETCH_CYC(S), .EXT_FILT(EXT_N), .LV_FILT(LV_N)) i_reset_supervisor (
    .clk(clk), .pwr_on_n(pwr_on_n), .ext_rst_n(ext_rst_n), .lowv_det(lowv_det),
    .usb_bus_rst(usb_bus_rst), .wdt_expire(wdt_expire), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cpu_rst(cpu_rst),
    .periph_rst_n(periph_rst_n), .lvr_en(lvr_en), .rst_cause(rst_cause)
  );

  // monitor: counts reset-high samples and inverse-output mismatches (R4)
  always @(negedge clk) begin
    if (cpu_rst === 1'b1) hi_cnt++;
    if (periph_rst_n !== ~cpu_rst) pmis++;
  end

  // stimulus table: [15:14] kind (0 pin,1 supply,2 usb,3 wdt), [13:8] length,
  // [7] reset expected, [3:0] expected cause
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 6'd7,  1'b0, 3'b0, 4'b0000},
    {2'd0, 6'd8,  1'b1, 3'b0, 4'b0001},
    {2'd1, 6'd3,  1'b0, 3'b0, 4'b0000},
    {2'd1, 6'd4,  1'b1, 3'b0, 4'b0010},
    {2'd2, 6'd1,  1'b1, 3'b0, 4'b0100},
    {2'd3, 6'd1,  1'b1, 3'b0, 4'b1000},
    {2'd0, 6'd20, 1'b1, 3'b0, 4'b0001},
    {2'd1, 6'd10, 1'b1, 3'b0, 4'b0010}
  };

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'd0: return "R1";
      2'd1: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (6) tick();
    for (int i = 0; i < 500 && cpu_rst; i++) tick();
    repeat (2) tick();
  endtask

  task automatic wr_reg(input logic sel, input logic [3:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic apply(input logic [1:0] kind, input int len);
    case (kind)
      2'd0: ext_rst_n = 1'b0;
      2'd1: lowv_det = 1'b1;
      2'd2: usb_bus_rst = 1'b1;
      default: wdt_expire = 1'b1;
    endcase
    repeat (len) tick();
    ext_rst_n = 1'b1; lowv_det = 1'b0; usb_bus_rst = 1'b0; wdt_expire = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (3) tick();
    // reset state R10, R4, R6, R8
    chk(cpu_rst === 1'b1, "R10 reset state cpu_rst", cpu_rst, 1);
    chk(periph_rst_n === 1'b0, "R4 reset state periph", periph_rst_n, 0);
    chk(lvr_en === 1'b1, "R6 lvr_en after power-on", lvr_en, 1);
    chk(rst_cause === 4'h0, "R8 cause after power-on", rst_cause, 0);
    pwr_on_n = 1'b1;
    #1 snap = hi_cnt;
    wait_idle();
    chk(hi_cnt - snap == S, "R10 power-on stretch", hi_cnt - snap, S);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wr_reg(1'b1, 4'hF);
      tick();
      snap = hi_cnt;
      apply(VEC[v][15:14], int'(VEC[v][13:8]));
      wait_idle();
      chk((hi_cnt != snap) == VEC[v][7], kind_tag(VEC[v][15:14]),
          int'(hi_cnt != snap), int'(VEC[v][7]));
      chk(rst_cause === VEC[v][3:0], {kind_tag(VEC[v][15:14]), " cause"},
          int'(rst_cause), int'(VEC[v][3:0]));
    end

    // R3: stretch length after a single watchdog pulse
    snap = hi_cnt;
    apply(2'd3, 1);
    wait_idle();
    chk(hi_cnt - snap == S + 1, "R3 wdt stretch length", hi_cnt - snap, S + 1);

    // R6 disable, R7 watchdog-only keeps it
    wr_reg(1'b1, 4'hF);
    wr_reg(1'b0, 4'h0);
    tick();
    chk(lvr_en === 1'b0, "R6 lvr_en written 0", lvr_en, 0);
    snap = hi_cnt;
    apply(2'd1, 10);
    wait_idle();
    chk(hi_cnt == snap, "R6 masked low supply", hi_cnt - snap, 0);
    chk(rst_cause === 4'h0, "R6 masked cause", rst_cause, 0);
    apply(2'd3, 1);
    wait_idle();
    chk(lvr_en === 1'b0, "R7 wdt-only keeps lvr_en", lvr_en, 0);
    apply(2'd2, 1);
    wait_idle();
    chk(lvr_en === 1'b1, "R6 usb reset sets lvr_en", lvr_en, 1);

    // R8 accumulation and replacement
    wr_reg(1'b1, 4'hF);
    apply(2'd3, 1);
    repeat (5) tick();
    apply(2'd2, 1);
    wait_idle();
    chk(rst_cause === 4'b1100, "R8 accumulate", rst_cause, 12);
    apply(2'd0, 10);
    wait_idle();
    chk(rst_cause === 4'b0001, "R8 replace on new reset", rst_cause, 1);

    // R9 write-one-to-clear and ignore during reset
    apply(2'd3, 1);
    repeat (5) tick();
    apply(2'd2, 1);
    wait_idle();
    wr_reg(1'b1, 4'b0100);
    tick();
    chk(rst_cause === 4'b1000, "R9 w1c partial", rst_cause, 8);
    apply(2'd3, 1);
    repeat (3) tick();
    wr_reg(1'b1, 4'hF);
    wr_reg(1'b0, 4'h0);
    wait_idle();
    chk(rst_cause === 4'b1000, "R9 write ignored in reset", rst_cause, 8);
    chk(lvr_en === 1'b1, "R6 ctrl write ignored in reset", lvr_en, 1);

    chk(pmis == 0, "R4 periph inverse mismatches", pmis, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule